// File: doc/BRIEF.md
# Power-of-Two Serial Clock Divider

This block produces the serial clock for a SPI shift engine by counting cycles of a base clock. The spacing between SCLK edges is a power of two, from 1 to 2048 base cycles, chosen by a 4-bit rate code. The two low code bits live in a control register and the two high code bits live in an extension register. Both registers are loaded through one narrow write port. SCLK therefore has a period of twice the selected ratio. Alongside SCLK the block gives the shifter a one-cycle marker for every rising and every falling SCLK edge. It also carries a high-speed mode flag, which the shifter uses and which has no effect on the rate.

The mapping from code to ratio is not monotonic: code 3 selects 16 and code 5 selects 8. Software uses the control register's enable bit to start and stop the clock. A new code waits for the end of the SCLK period in progress, so the shifter never sees a shortened high or low phase.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset SCLK, both edge markers and `hs_mode` are low. The control register resets with enable set and low code bits 01, and the extension register resets to zero. The first rising SCLK edge therefore comes 2 base cycles after reset is released.
- R2: With the clock enabled, successive SCLK edges are N base cycles apart. N follows the code: 0→1, 1→2, 2→4, 5→8, 3→16, 4→32, 6→64, 7→128, 8→256, 9→512, 10→1024, 11→2048.
- R3: A write with `wr_sel`=0 loads the control register. Its bits [1:0] become code bits [1:0] and its bit 4 is the enable. A write with `wr_sel`=1 loads the extension register. Its bits [1:0] become code bits [3:2].
- R4: Codes 12, 13, 14 and 15 give an edge spacing of 1 base cycle.
- R5: While the enable bit is 0, SCLK stays low and neither edge marker pulses. This starts from the second cycle after the disabling write.
- R6: `sclk_rise` is high for exactly the one cycle in which SCLK first reads 1. `sclk_fall` is high for exactly the one cycle in which SCLK first reads 0 after being high. The two markers are never high together.
- R7: A code written while SCLK runs leaves the current period unchanged, both the rest of its high half and its falling edge. The new spacing starts with the low half that follows that falling edge.
- R8: Bit 4 of the extension register appears on `hs_mode` in the cycle after the write, and it does not change the edge spacing.
- R9: When a write sets the enable bit, the first rising SCLK edge comes N base cycles after that write. N is taken from the code held after that same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the extension register |
| wr_data | input | 8 | Write data |
| sclk | output | 1 | Divided serial clock, low when disabled |
| sclk_rise | output | 1 | One-cycle marker of a rising SCLK edge |
| sclk_fall | output | 1 | One-cycle marker of a falling SCLK edge |
| hs_mode | output | 1 | High-speed clocking flag for the shifter |

## Verification
The assertions assume that `wr_en`, `wr_sel` and `wr_data` are steady around the sampling edge. They also assume that reset is held for at least one edge before any property is judged, and the bench meets both by driving every input on the falling edge. The edge-marker and phase-hold properties assume the rate code can change at any time, including in the middle of a high half. The bench therefore rewrites the code during a high phase on purpose, and it reprograms codes only while disabled in the table walk, so that each measured spacing belongs to one code.

// File: rtl/sclk_div_pkg.sv
// Shared constants and the rate-code decode for the serial clock divider.
// Assumes an 8-bit register write port and a 4-bit rate code.
package sclk_div_pkg;
    localparam int REG_W     = 8;
    localparam int CODE_W    = 4;
    localparam int EXP_W     = 4;
    localparam int MAX_EXP   = 11;
    localparam int EN_BIT    = 4;
    localparam int HS_BIT    = 4;
    localparam logic [REG_W-1:0] CTRL_INIT = 8'hD1;
    localparam logic [REG_W-1:0] EXT_INIT  = 8'h00;

    // Map a rate code to log2 of the edge spacing; unused codes fall back to 0.
    function automatic logic [EXP_W-1:0] code_to_exp(input logic [CODE_W-1:0] code);
        logic [EXP_W-1:0] e;
        case (code)
            4'd0:    e = 4'd0;
            4'd1:    e = 4'd1;
            4'd2:    e = 4'd2;
            4'd3:    e = 4'd4;
            4'd4:    e = 4'd5;
            4'd5:    e = 4'd3;
            4'd6:    e = 4'd6;
            4'd7:    e = 4'd7;
            4'd8:    e = 4'd8;
            4'd9:    e = 4'd9;
            4'd10:   e = 4'd10;
            4'd11:   e = 4'd11;
            default: e = 4'd0;
        endcase
        return e;
    endfunction
endpackage

// File: rtl/sclk_div_regs.sv
// Holds the control and extension registers of the divider.
// Assumes single-cycle writes sampled on the rising edge of clk.
module sclk_div_regs
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             run_en,
    output logic [1:0]       code_lo,
    output logic [1:0]       code_hi,
    output logic             hs_flag
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] ext_q;
    logic             unused_reg_bits;

    // Load whichever register the select picks; reset to the enabled defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
            ext_q  <= EXT_INIT;
        end else if (wr_en) begin
            if (wr_sel) ext_q  <= wr_data;
            else        ctrl_q <= wr_data;
        end
    end

    assign run_en  = ctrl_q[EN_BIT];
    assign code_lo = ctrl_q[1:0];
    assign code_hi = ext_q[1:0];
    assign hs_flag = ext_q[HS_BIT];
    assign unused_reg_bits = ^{ctrl_q[REG_W-1:EN_BIT+1], ctrl_q[EN_BIT-1:2],
                               ext_q[REG_W-1:HS_BIT+1], ext_q[HS_BIT-1:2]};

    // R3: a control write lands in the low code bits and enable one cycle later
    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (code_lo == $past(wr_data[1:0]) && run_en == $past(wr_data[EN_BIT])));

    // R8: the high-speed flag follows an extension write one cycle later
    a_r8_hs_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (hs_flag == $past(wr_data[HS_BIT]) && code_hi == $past(wr_data[1:0])));
endmodule

// File: rtl/sclk_div_decode.sv
// Joins the two code fields and turns the rate code into an exponent.
// Assumes the code fields come straight from registers.
module sclk_div_decode
    import sclk_div_pkg::*;
(
    input  logic [1:0]       code_lo,
    input  logic [1:0]       code_hi,
    output logic [EXP_W-1:0] exp_req
);
    logic [CODE_W-1:0] code;

    // Assemble the code and look up its exponent.
    always_comb begin
        code    = {code_hi, code_lo};
        exp_req = code_to_exp(code);
    end

    // R2: the exponent never asks for more than the widest counter
    always_comb begin
        a_r2_exp_range: assert (exp_req <= EXP_W'(MAX_EXP));
    end
endmodule

// File: rtl/sclk_div_engine.sv
// Counts base cycles between SCLK edges and toggles SCLK at each terminal count.
// Assumes exp_req never exceeds MAX_EXP; it samples a new exponent only at a
// falling edge or in the first enabled cycle, so no phase is ever shortened.
module sclk_div_engine #(
    parameter int MAX_EXP = 11,
    parameter int EXP_W   = 4,
    localparam int CNT_W  = (MAX_EXP > 0) ? MAX_EXP : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EXP_W-1:0] exp_req,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [EXP_W-1:0] exp_act;
    logic [EXP_W-1:0] exp_use;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             en_d;
    logic             first;
    logic             at_end;

    assign first   = en && !en_d;
    assign exp_use = first ? exp_req : exp_act;

    // Terminal count is 2^exp - 1: bit i is set when the exponent exceeds i.
    for (genvar i = 0; i < CNT_W; i++) begin : g_lim
        assign lim[i] = (exp_use > EXP_W'(i));
    end

    assign at_end = (cnt == lim);

    // Advance the edge counter, toggle SCLK at terminal count, latch a new rate at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sclk      <= 1'b0;
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
            exp_act   <= '0;
            en_d      <= 1'b0;
        end else if (!en) begin
            cnt       <= '0;
            sclk      <= 1'b0;
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
            exp_act   <= exp_req;
            en_d      <= 1'b0;
        end else begin
            en_d      <= 1'b1;
            rise_tick <= 1'b0;
            fall_tick <= 1'b0;
            if (first) exp_act <= exp_req;
            if (at_end) begin
                cnt       <= '0;
                sclk      <= !sclk;
                rise_tick <= !sclk;
                fall_tick <= sclk;
                if (sclk) exp_act <= exp_req;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: a disabled cycle leaves SCLK low with no markers
    a_r5_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk && !rise_tick && !fall_tick));

    // R6: markers never coincide
    a_r6_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick, fall_tick}));

    // R6: a rise marker coincides with SCLK turning high
    a_r6_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> (sclk && !$past(sclk)));

    // R6: a fall marker coincides with SCLK turning low
    a_r6_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |-> (!sclk && $past(sclk)));

    // R7: the active rate stays put through a high phase
    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(exp_act));

    // R2: the counter never runs past its terminal count
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
endmodule

// File: rtl/sclk_rate_gen.sv
// Top of the serial clock divider: register file, code decode and edge engine.
// Assumes clk is the base clock and all inputs are synchronous to it.
module sclk_rate_gen
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall,
    output logic             hs_mode
);
    logic             run_en;
    logic [1:0]       code_lo;
    logic [1:0]       code_hi;
    logic [EXP_W-1:0] exp_req;

    sclk_div_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .run_en  (run_en),
        .code_lo (code_lo),
        .code_hi (code_hi),
        .hs_flag (hs_mode)
    );

    sclk_div_decode u_decode (
        .code_lo (code_lo),
        .code_hi (code_hi),
        .exp_req (exp_req)
    );

    sclk_div_engine #(
        .MAX_EXP (MAX_EXP),
        .EXP_W   (EXP_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .exp_req   (exp_req),
        .sclk      (sclk),
        .rise_tick (sclk_rise),
        .fall_tick (sclk_fall)
    );
endmodule

// File: tb/sclk_rate_gen_test.sv
// Bench for the serial clock divider: a code/ratio table walk, then directed cases.
module sclk_rate_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 6000;

    // [15:12] rate code, [11:0] expected edge spacing in base cycles
    localparam logic [15:0] VEC [16] = '{
        {4'd0,  12'd1},    {4'd1,  12'd2},    {4'd2,  12'd4},    {4'd3,  12'd16},
        {4'd4,  12'd32},   {4'd5,  12'd8},    {4'd6,  12'd64},   {4'd7,  12'd128},
        {4'd8,  12'd256},  {4'd9,  12'd512},  {4'd10, 12'd1024}, {4'd11, 12'd2048},
        {4'd12, 12'd1},    {4'd13, 12'd1},    {4'd14, 12'd1},    {4'd15, 12'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sclk, sclk_rise, sclk_fall, hs_mode;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    sclk_rate_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .hs_mode   (hs_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait for a marker (0 = rise, 1 = fall); returns the cycle count it was seen at.
    task automatic wait_tick(input bit which, output int at);
        at = -1;
        for (int k = 0; k < WAIT_LIMIT; k++) begin
            @(negedge clk);
            if ((which == 1'b0 && sclk_rise) || (which == 1'b1 && sclk_fall)) begin
                at = cyc;
                break;
            end
        end
        if (at < 0) begin
            checks++; failures++;
            $display("FAIL wait for edge marker: actual=none expected=marker");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0, cw, r, f, r2;
        logic [3:0] code;
        int n;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sclk in reset", sclk, 0);
        check("R1 markers in reset", sclk_rise | sclk_fall, 0);
        check("R1 hs_mode in reset", hs_mode, 0);
        rst_n = 1'b1;
        c0 = cyc;
        wait_tick(1'b0, r);
        check("R1 first rise after reset at default /2", r - c0, 2);
        wait_tick(1'b1, f);
        check("R1 default spacing", f - r, 2);

        // Table walk: R2, R3, R4, R9
        foreach (VEC[i]) begin
            code = VEC[i][15:12];
            n    = int'(VEC[i][11:0]);
            write_reg(1'b0, {6'b0, code[1:0]});
            write_reg(1'b1, {6'b0, code[3:2]});
            write_reg(1'b0, {6'b110100, code[1:0]});
            cw = cyc;
            wait_tick(1'b0, r);
            check("R9 first rise after enable", r - cw, n);
            check("R6 sclk high at rise marker", sclk, 1);
            wait_tick(1'b1, f);
            check("R6 sclk low at fall marker", sclk, 0);
            if (code >= 4'd12) check("R4 spacing for unused code", f - r, n);
            else               check("R2 high-half spacing", f - r, n);
            wait_tick(1'b0, r2);
            check("R2 low-half spacing", r2 - f, n);
        end

        // R5: disable holds SCLK low with no markers
        write_reg(1'b0, 8'h01);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            check("R5 sclk held low", sclk, 0);
            check("R5 no markers", sclk_rise | sclk_fall, 0);
            @(negedge clk);
        end

        // R6, R7: run at /8, rewrite to /2 inside a high half
        write_reg(1'b0, 8'h01);
        write_reg(1'b1, 8'h01);
        write_reg(1'b0, 8'hD1);
        wait_tick(1'b0, r);
        @(negedge clk);
        check("R6 rise marker lasts one cycle", sclk_rise, 0);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        wait_tick(1'b1, f);
        check("R7 current period keeps old spacing", f - r, 8);
        wait_tick(1'b0, r2);
        check("R7 new spacing from next period", r2 - f, 2);

        // R8: high-speed flag follows and leaves spacing alone (code 2, /4)
        write_reg(1'b1, 8'h10);
        check("R8 hs_mode set", hs_mode, 1);
        write_reg(1'b0, 8'hD2);
        wait_tick(1'b0, r);
        wait_tick(1'b1, f);
        check("R8 spacing unchanged by hs", f - r, 4);
        write_reg(1'b1, 8'h00);
        check("R8 hs_mode cleared", hs_mode, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule